// File: doc/BRIEF.md
# Pin Configuration Register Bank

This block keeps one 32-bit configuration word for each of 32 port pins. Each word holds the settings that pad logic needs: pull selection, slew, passive input filtering, open-drain, drive strength, the 3-bit function selector, a lock flag and a 4-bit interrupt-condition code. The bank is reached over a plain register bus with a write strobe and a combinational read path. Every stored field also drives a dedicated output toward the pads.

Besides the per-pin words there are two broadcast addresses. A write to either one copies its lower half-word into the lower half of every pin that its upper half-word selects. All selected pins update on the same clock edge. One broadcast address serves pins 0 to 15 and the other serves pins 16 to 31.

Once software sets a pin's lock flag, the lower half of that pin's word is frozen until reset. The interrupt-condition code in the upper half stays writable.

Top module: `pcr_bank`

## Requirements
- R1: While rstN is low, every pin word clears to zero. All pad outputs then read zero, which means function 0 (disabled/analog), pull code 0 (no pull), not locked, and interrupt code 0.
- R2: A bus write to address i (0 to 31) stores only the implemented bits of pin i. Those bits are [1:0], 2, 4, 5, 6, [10:8], 15 and [19:16]. Every other bit of a pin word reads as zero.
- R3: The fields of each pin word drive the pad outputs as follows.
  - pullSel: bits [1:0], where 0 is none, 2 is pull-down and 3 is pull-up.
  - slewSlow: bit 2.
  - filtEn: bit 4.
  - openDrain: bit 5.
  - driveHigh: bit 6.
  - funcSel: bits [10:8], where 0 is disabled/analog, 1 is GPIO and 2 to 7 are alternate functions.
  - pinLocked: bit 15.
  - intCfg: bits [19:16].
- R4: A write to address 32 treats data bit 16+k as the select for pin k (k = 0 to 15). It copies data[15:0], masked to the implemented bits, into bits [15:0] of each selected pin. Unselected pins are unchanged, and bits [19:16] of every pin are unchanged.
- R5: A write to address 33 treats data bit 16+k as the select for pin 16+k (k = 0 to 15). It otherwise behaves as R4.
- R6: A broadcast write updates all selected pins on the same clock edge.
- R7: While bit 15 of a pin word is set, bits [15:0] of that word ignore both direct writes and broadcast writes.
- R8: After the lock bit has been set, only reset clears it. Writing 0 to bit 15 leaves it set.
- R9: A direct write to a locked pin still updates that pin's bits [19:16].
- R10: Reads of address 32, 33 or any address above 33 return zero. Writes to addresses above 33 change nothing.
- R11: busRdData shows the word at busAddr in the same cycle. A write becomes visible on the read path after the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 6 | Word address: 0-31 pin words, 32/33 broadcast |
| busWrEn | input | 1 | Write strobe for the current address |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr (combinational) |
| pullSel | output | 64 | Pull code, 2 bits per pin |
| slewSlow | output | 32 | Slow-slew enable per pin |
| filtEn | output | 32 | Passive filter enable per pin |
| openDrain | output | 32 | Open-drain enable per pin |
| driveHigh | output | 32 | High drive strength per pin |
| funcSel | output | 96 | Function selector, 3 bits per pin |
| pinLocked | output | 32 | Lock flag per pin |
| intCfg | output | 128 | Interrupt-condition code, 4 bits per pin |

## Verification
Every stored bit leaves the block on a pad output without passing through another register. A corrupted pin word therefore shows up at the pads on the first negative clock edge after the faulty update, and on busRdData as soon as that pin is addressed. A lock that fails to hold appears as a pad field changing in the cycle after a write to a locked pin, whether that write was direct or broadcast. A broadcast that misses a pin or reaches the wrong one shows as a mismatch on that pin's pads right after the single accepting edge.

// File: rtl/pcr_pkg.sv
package pcr_pkg;
  localparam int NUM_PINS = 32;
  localparam int PIN_W    = $clog2(NUM_PINS);
  localparam int ADDR_W   = PIN_W + 1;
  localparam int GRP      = NUM_PINS / 2;
  localparam int WORD_W   = 32;
  localparam int HALF_W   = WORD_W / 2;
  localparam int PULL_W   = 2;
  localparam int FSEL_W   = 3;
  localparam int ICFG_W   = 4;

  localparam int PULL_LSB = 0;
  localparam int SLEW_BIT = 2;
  localparam int FILT_BIT = 4;
  localparam int OD_BIT   = 5;
  localparam int DRV_BIT  = 6;
  localparam int FSEL_LSB = 8;
  localparam int LOCK_BIT = 15;
  localparam int ICFG_LSB = HALF_W;

  localparam logic [ADDR_W-1:0] ADDR_BCAST_LO = ADDR_W'(NUM_PINS);
  localparam logic [ADDR_W-1:0] ADDR_BCAST_HI = ADDR_W'(NUM_PINS + 1);

  // implemented bits of the lower half-word
  localparam logic [HALF_W-1:0] LOW_KEEP =
      (HALF_W'((1 << PULL_W) - 1) << PULL_LSB) |
      (HALF_W'(1) << SLEW_BIT) | (HALF_W'(1) << FILT_BIT) |
      (HALF_W'(1) << OD_BIT)   | (HALF_W'(1) << DRV_BIT)  |
      (HALF_W'((1 << FSEL_W) - 1) << FSEL_LSB) |
      (HALF_W'(1) << LOCK_BIT);

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_PINS-1:0] lowWr;
    logic [NUM_PINS-1:0] icfgWr;
    logic [HALF_W-1:0]   lowData;
    logic [ICFG_W-1:0]   icfgData;
  } pcrStrobe_t;
endpackage

// File: rtl/pcr_ctrl.sv
module pcr_ctrl
  import pcr_pkg::*;
(
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic                          busWrEn,
  input  logic [WORD_W-1:0]             busWrData,
  input  logic [NUM_PINS-1:0][WORD_W-1:0] pinWord,
  output pcrStrobe_t                    strb,
  output logic [WORD_W-1:0]             busRdData
);
  logic pinHit;
  logic [PIN_W-1:0] pinIdx;

  assign pinHit = (busAddr[ADDR_W-1] == 1'b0);
  assign pinIdx = busAddr[PIN_W-1:0];

  always_comb begin
    strb          = '0;
    strb.lowData  = busWrData[HALF_W-1:0];
    strb.icfgData = busWrData[ICFG_LSB +: ICFG_W];
    if (busWrEn) begin
      if (pinHit) begin
        strb.lowWr[pinIdx]  = 1'b1;
        strb.icfgWr[pinIdx] = 1'b1;
      end else if (busAddr == ADDR_BCAST_LO) begin
        for (int k = 0; k < GRP; k++) strb.lowWr[k] = busWrData[HALF_W + k];
      end else if (busAddr == ADDR_BCAST_HI) begin
        for (int k = 0; k < GRP; k++) strb.lowWr[GRP + k] = busWrData[HALF_W + k];
      end
    end
  end

  assign busRdData = pinHit ? pinWord[pinIdx] : '0;
endmodule

// File: rtl/pcr_datapath.sv
module pcr_datapath
  import pcr_pkg::*;
(
  input  logic                            clk,
  input  logic                            rstN,
  input  pcrStrobe_t                      strb,
  output logic [NUM_PINS-1:0][WORD_W-1:0] pinWord,
  output logic [NUM_PINS*PULL_W-1:0]      pullSel,
  output logic [NUM_PINS-1:0]             slewSlow,
  output logic [NUM_PINS-1:0]             filtEn,
  output logic [NUM_PINS-1:0]             openDrain,
  output logic [NUM_PINS-1:0]             driveHigh,
  output logic [NUM_PINS*FSEL_W-1:0]      funcSel,
  output logic [NUM_PINS-1:0]             pinLocked,
  output logic [NUM_PINS*ICFG_W-1:0]      intCfg
);
  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic [HALF_W-1:0] lowQ;
    logic [ICFG_W-1:0] icfgQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lowQ  <= '0;
        icfgQ <= '0;
      end else begin
        if (strb.lowWr[i] && !lowQ[LOCK_BIT]) lowQ <= strb.lowData & LOW_KEEP;
        if (strb.icfgWr[i]) icfgQ <= strb.icfgData;
      end
    end

    assign pinWord[i] = {{(HALF_W - ICFG_W){1'b0}}, icfgQ, lowQ};
    assign pullSel[i*PULL_W +: PULL_W] = lowQ[PULL_LSB +: PULL_W];
    assign slewSlow[i]                 = lowQ[SLEW_BIT];
    assign filtEn[i]                   = lowQ[FILT_BIT];
    assign openDrain[i]                = lowQ[OD_BIT];
    assign driveHigh[i]                = lowQ[DRV_BIT];
    assign funcSel[i*FSEL_W +: FSEL_W] = lowQ[FSEL_LSB +: FSEL_W];
    assign pinLocked[i]                = lowQ[LOCK_BIT];
    assign intCfg[i*ICFG_W +: ICFG_W]  = icfgQ;
  end
endmodule

// File: rtl/pcr_bank.sv
module pcr_bank
  import pcr_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [ADDR_W-1:0]          busAddr,
  input  logic                       busWrEn,
  input  logic [WORD_W-1:0]          busWrData,
  output logic [WORD_W-1:0]          busRdData,
  output logic [NUM_PINS*PULL_W-1:0] pullSel,
  output logic [NUM_PINS-1:0]        slewSlow,
  output logic [NUM_PINS-1:0]        filtEn,
  output logic [NUM_PINS-1:0]        openDrain,
  output logic [NUM_PINS-1:0]        driveHigh,
  output logic [NUM_PINS*FSEL_W-1:0] funcSel,
  output logic [NUM_PINS-1:0]        pinLocked,
  output logic [NUM_PINS*ICFG_W-1:0] intCfg
);
  pcrStrobe_t                      strb;
  logic [NUM_PINS-1:0][WORD_W-1:0] pinWord;

  pcr_ctrl u_ctrl (
    .busAddr   (busAddr),
    .busWrEn   (busWrEn),
    .busWrData (busWrData),
    .pinWord   (pinWord),
    .strb      (strb),
    .busRdData (busRdData)
  );

  pcr_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .pinWord   (pinWord),
    .pullSel   (pullSel),
    .slewSlow  (slewSlow),
    .filtEn    (filtEn),
    .openDrain (openDrain),
    .driveHigh (driveHigh),
    .funcSel   (funcSel),
    .pinLocked (pinLocked),
    .intCfg    (intCfg)
  );
endmodule

// File: rtl/pcr_bank_checker.sv
module pcr_bank_checker
  import pcr_pkg::*;
(
  input logic                       clk,
  input logic                       rstN,
  input logic [ADDR_W-1:0]          busAddr,
  input logic                       busWrEn,
  input logic [WORD_W-1:0]          busWrData,
  input logic [WORD_W-1:0]          busRdData,
  input logic [NUM_PINS*PULL_W-1:0] pullSel,
  input logic [NUM_PINS-1:0]        slewSlow,
  input logic [NUM_PINS-1:0]        filtEn,
  input logic [NUM_PINS-1:0]        openDrain,
  input logic [NUM_PINS-1:0]        driveHigh,
  input logic [NUM_PINS*FSEL_W-1:0] funcSel,
  input logic [NUM_PINS-1:0]        pinLocked,
  input logic [NUM_PINS*ICFG_W-1:0] intCfg
);
  localparam logic [WORD_W-1:0] RD_KEEP = {{(HALF_W - ICFG_W){1'b0}}, {ICFG_W{1'b1}}, LOW_KEEP};

  p_reset_clear_r1: assert property (@(posedge clk)
    !rstN |=> (pinLocked == '0 && funcSel == '0 && pullSel == '0 && intCfg == '0));

  p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busRdData & ~RD_KEEP) == '0);

  p_non_pin_read_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    busAddr[ADDR_W-1] |-> busRdData == '0);

  p_global_keeps_icfg_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr[ADDR_W-1]) |=> $stable(intCfg));

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
    p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
      pinLocked[i] |=> pinLocked[i]);

    p_locked_frozen_r7: assert property (@(posedge clk) disable iff (!rstN)
      pinLocked[i] |=> ($stable(pullSel[i*PULL_W +: PULL_W]) && $stable(slewSlow[i]) &&
                        $stable(filtEn[i]) && $stable(openDrain[i]) && $stable(driveHigh[i]) &&
                        $stable(funcSel[i*FSEL_W +: FSEL_W])));

    p_icfg_write_r9: assert property (@(posedge clk) disable iff (!rstN)
      (busWrEn && busAddr == ADDR_W'(i)) |=>
        intCfg[i*ICFG_W +: ICFG_W] == $past(busWrData[ICFG_LSB +: ICFG_W]));
  end
endmodule

bind pcr_bank pcr_bank_checker u_chk (.*);

// File: tb/pcr_bank_tb.sv
module pcr_bank_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [5:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [63:0] pullSel;
  logic [31:0] slewSlow, filtEn, openDrain, driveHigh, pinLocked;
  logic [95:0] funcSel;
  logic [127:0] intCfg;

  logic [31:0] expReg [32];
  int nChecks = 0;
  int nFails  = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pcr_bank u_dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic modelWrite(input logic [5:0] a, input logic [31:0] d);
    if (a < 6'd32) begin
      if (!expReg[a][15]) expReg[a][15:0] = d[15:0] & 16'h8777;
      expReg[a][19:16] = d[19:16];
    end else if (a == 6'd32 || a == 6'd33) begin
      for (int k = 0; k < 16; k++) begin
        int p = (a == 6'd32) ? k : k + 16;
        if (d[16+k] && !expReg[p][15]) expReg[p][15:0] = d[15:0] & 16'h8777;
      end
    end
  endtask

  task automatic busWrite(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    modelWrite(a, d);
  endtask

  task automatic busRead(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrEn = 1'b0;
    #1 d = busRdData;
  endtask

  function automatic logic [31:0] padWord(input int i);
    return {12'b0, intCfg[i*4 +: 4], pinLocked[i], 4'b0, funcSel[i*3 +: 3], 1'b0,
            driveHigh[i], openDrain[i], filtEn[i], 1'b0, slewSlow[i], pullSel[i*2 +: 2]};
  endfunction

  task automatic checkPads(input string req);
    for (int i = 0; i < 32; i++) begin
      logic [31:0] w;
      w = padWord(i);
      chk(w == expReg[i], $sformatf("%s pads pin %0d", req, i), w, expReg[i]);
    end
  endtask

  task automatic checkAll(input string req);
    for (int i = 0; i < 32; i++) begin
      logic [31:0] d;
      busRead(6'(i), d);
      chk(d == expReg[i], $sformatf("%s read pin %0d", req, i), d, expReg[i]);
    end
    checkPads(req);
  endtask

  task automatic resetDut();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    for (int i = 0; i < 32; i++) expReg[i] = '0;
  endtask

  task automatic t_reset();
    resetDut();
    checkAll("R1");
  endtask

  task automatic t_direct();
    logic [31:0] d;
    busWrite(6'd3, 32'hFFFF_7FFF);
    busRead(6'd3, d);
    chk(d == 32'h000F_0777, "R2 reserved bits zero", d, 32'h000F_0777);
    chk(pullSel[7:6] == 2'd3 && funcSel[11:9] == 3'd7 && intCfg[15:12] == 4'hF,
        "R3 pin3 fields", padWord(3), 32'h000F_0777);
    busWrite(6'd5, 32'h0000_0102);
    chk(pullSel[11:10] == 2'd2 && funcSel[17:15] == 3'd1, "R3 pull-down GPIO", padWord(5), 32'h0000_0102);
    checkAll("R2");
  endtask

  task automatic t_bcastLow();
    busWrite(6'd32, {16'h00AD, 16'h0352});
    checkPads("R6");
    checkAll("R4");
  endtask

  task automatic t_bcastHigh();
    logic [31:0] d;
    busWrite(6'd33, {16'h8001, 16'h0007});
    checkPads("R6");
    busRead(6'd31, d);
    chk(d == 32'h0000_0007, "R5 pin31", d, 32'h0000_0007);
    busRead(6'd15, d);
    chk(d == 32'h0000_0000, "R5 pin15 untouched", d, 32'h0);
    checkAll("R5");
  endtask

  task automatic t_lock();
    logic [31:0] d;
    busWrite(6'd10, 32'h0000_8103);
    chk(pinLocked[10] == 1'b1, "R7 lock set", {31'b0, pinLocked[10]}, 32'h1);
    busWrite(6'd10, 32'h0000_0000);
    busRead(6'd10, d);
    chk(d == 32'h0000_8103, "R8 lock not cleared by write", d, 32'h0000_8103);
    busWrite(6'd32, {16'h0C00, 16'h0010});
    busRead(6'd10, d);
    chk(d == 32'h0000_8103, "R7 locked pin ignores broadcast", d, 32'h0000_8103);
    busRead(6'd11, d);
    chk(d == 32'h0000_0010, "R4 unlocked neighbour written", d, 32'h0000_0010);
    busWrite(6'd10, 32'h000A_0000);
    busRead(6'd10, d);
    chk(d == 32'h000A_8103, "R9 icfg on locked pin", d, 32'h000A_8103);
    checkAll("R7");
  endtask

  task automatic t_readTiming();
    @(negedge clk);
    busAddr = 6'd20; busWrData = 32'h0000_0100; busWrEn = 1'b1;
    #1 chk(busRdData == expReg[20], "R11 old value before edge", busRdData, expReg[20]);
    @(negedge clk);
    busWrEn = 1'b0;
    modelWrite(6'd20, 32'h0000_0100);
    #1 chk(busRdData == 32'h0000_0100, "R11 new value after edge", busRdData, 32'h0000_0100);
  endtask

  task automatic t_reservedAddr();
    logic [31:0] d;
    busWrite(6'd40, 32'hFFFF_FFFF);
    busRead(6'd40, d);
    chk(d == '0, "R10 read 40", d, '0);
    busRead(6'd32, d);
    chk(d == '0, "R10 read 32", d, '0);
    busRead(6'd33, d);
    chk(d == '0, "R10 read 33", d, '0);
    checkAll("R10");
  endtask

  task automatic t_resetUnlock();
    resetDut();
    chk(pinLocked == '0, "R8 reset clears lock", pinLocked, '0);
    checkAll("R1");
  endtask

  initial begin
    for (int i = 0; i < 32; i++) expReg[i] = '0;
    t_reset();
    t_direct();
    t_bcastLow();
    t_bcastHigh();
    t_lock();
    t_readTiming();
    t_reservedAddr();
    t_resetUnlock();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog act=%h exp=%h", 32'h0, 32'h1);
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end
endmodule